// File: doc/BRIEF.md
# Four-Event Edge Capture Timer

This block records when edges occur on one input signal. A free-running timestamp counter advances by one on every clock. Each time a qualifying edge arrives, the counter value is copied into one of four capture slots. A small sequencer steps through the slots in a fixed order and returns to the first slot after a programmable last event. Each slot has its own edge polarity. Each slot can also clear the counter right after it captures, so software can read either absolute timestamps or the time between edges.

The sequencer runs continuously or stops after the last event until software re-arms it. The stream of input edges can be thinned by a prescaler before it reaches the sequencer. Every event, and every counter wrap, sets a sticky flag. A single interrupt line is driven by a global flag. The global flag sets only when an enabled source fires and stays set until software clears it. The host reaches the block through a flat word-addressed read/write port. Reads are combinational.

Top module: `edge_stamp_timer`

## Requirements
- R1: After reset, all four capture slots, the counter, the flag word, the control word and `irq` read as zero.
- R2: The counter (address 0x4) holds its value while control bit 0 (run) is 0. While run is 1, the counter increases by one per clock.
- R3: The input passes through a two-flop synchroniser. When an edge is recognised, the current slot (addresses 0x8..0xB for events 1..4) loads the counter value that was present three clock edges after the input changed. That value equals the counter read on the cycle of the change plus 2.
- R4: Control bit 16+k-1 sets the polarity of event k: 0 means a rising edge and 1 means a falling edge. An edge of the other polarity neither captures nor advances the sequence.
- R5: When control bit 20+k-1 is set, event k stores the value the counter had before the clear, and the counter restarts from 0 on the next cycle. Consecutive captures therefore read the edge distance minus 1.
- R6: Control bits 4:3 hold the index of the last event minus 1. After that event the sequence returns to event 1.
- R7: When control bit 2 is set (one-shot mode), the block stops after the last event and ignores further edges. Writing control with bit 5 set re-arms the block: the sequence restarts at event 1 and the prescaler count is cleared.
- R8: When control bit 1 (load enable) is 0, the capture slots keep their values, but event flags still set and the sequence still advances.
- R9: Control bits 12:8 hold a prescale value P. When P is 0, every qualifying edge is an event. When P is greater than 0, only every 2P-th qualifying edge is an event.
- R10: When the counter wraps from its maximum value to 0, flag bit 5 sets.
- R11: The flag word (address 0x2) keeps event k in bit k and the overflow in bit 5, and these flags are sticky. Writing 1 to a bit at address 0x3 clears that flag. Writing 0 to a bit has no effect.
- R12: The enable word (address 0x1) uses bits 4:1 for the events and bit 5 for overflow. Flag bit 0, which drives `irq`, sets only when an enabled source fires. It stays set until bit 0 is written to address 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Monitored asynchronous signal |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| irq | output | 1 | Interrupt request (global flag) |

## Verification
An input change driven between clock edges becomes a capture on the third rising edge after it. The capture holds the counter value read on the cycle of the change plus 2. Flags and `irq` are registered on that same edge. Register writes take effect on the edge that ends the write cycle. The bench therefore reads the counter in the cycle it changes the input, waits four whole cycles, and only then reads slots, flags or `irq`, half a period away from any edge. In delta mode the expected slot values come from the number of cycles between input changes.

// File: rtl/est_pkg.sv
package est_pkg;
  localparam int NUM_EV = 4;
  localparam int PRE_W  = 5;
  localparam int SEEN_W = PRE_W + 1;

  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_IEN  = 4'h1;
  localparam logic [3:0] ADDR_FLAG = 4'h2;
  localparam logic [3:0] ADDR_CLR  = 4'h3;
  localparam logic [3:0] ADDR_CNT  = 4'h4;

  localparam int BIT_GINT = 0;
  localparam int BIT_OVF  = 5;

  typedef struct packed {
    logic [3:0]       rst_after;
    logic [3:0]       fall_sel;
    logic [2:0]       rsv_hi;
    logic [PRE_W-1:0] prescale;
    logic [1:0]       rsv_lo;
    logic             rearm;
    logic [1:0]       wrap;
    logic             one_shot;
    logic             load_en;
    logic             run;
  } est_ctrl_t;

  // next slot index in the modulo sequence
  function automatic logic [1:0] seq_next(input logic [1:0] ptr, input logic [1:0] wrap);
    return (ptr == wrap) ? 2'd0 : ptr + 2'd1;
  endfunction

  // true when this qualifying edge is the one the prescaler lets through
  function automatic logic presc_due(input logic [SEEN_W-1:0] seen, input logic [PRE_W-1:0] div);
    logic [SEEN_W-1:0] lim;
    lim = {div, 1'b0} - SEEN_W'(1);
    return (div == '0) || (seen == lim);
  endfunction

  function automatic logic [31:0] pack_flags(input logic gint, input logic [3:0] ev, input logic ovf);
    return {26'd0, ovf, ev, gint};
  endfunction
endpackage

// File: rtl/est_edge_sync.sv
module est_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/est_sequencer.sv
module est_sequencer
  import est_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [3:0]       fall_sel,
  input  logic [1:0]       wrap,
  input  logic             one_shot,
  input  logic [PRE_W-1:0] prescale,
  input  logic             rearm,
  output logic             fire,
  output logic [NUM_EV-1:0] evt
);
  logic [1:0]        ptr_q;
  logic              stopped_q;
  logic [SEEN_W-1:0] seen_q;
  logic              pick;
  logic              qual;

  assign pick = fall_sel[ptr_q] ? fall : rise;
  assign qual = pick & ~stopped_q;
  assign fire = qual & presc_due(seen_q, prescale);

  always_comb begin
    evt = '0;
    if (fire) evt[ptr_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= 2'd0;
      stopped_q <= 1'b0;
      seen_q    <= '0;
    end else if (rearm) begin
      ptr_q     <= 2'd0;
      stopped_q <= 1'b0;
      seen_q    <= '0;
    end else if (fire) begin
      ptr_q  <= seq_next(ptr_q, wrap);
      seen_q <= '0;
      if (one_shot && (ptr_q == wrap)) stopped_q <= 1'b1;
    end else if (qual) begin
      seen_q <= seen_q + SEEN_W'(1);
    end
  end

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && one_shot && (ptr_q == wrap) && !rearm) |=> stopped_q); // R7
  AST_WRAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (ptr_q == wrap) && !rearm) |=> (ptr_q == 2'd0)); // R6
  AST_REARM_START: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (ptr_q == 2'd0) && !stopped_q); // R7
endmodule

// File: rtl/est_counter.sv
module est_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_pulse
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt        = cnt_q;
  assign wrap_pulse = run & ~clr & (&cnt_q);

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
  import est_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sig_in,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  est_ctrl_t          ctrl_q;
  logic [5:1]         ien_q;
  logic [NUM_EV-1:0]  ev_flag_q;
  logic               ovf_flag_q;
  logic               gint_q;
  logic [CNT_W-1:0]   cap_q [NUM_EV];

  logic               rise, fall, fire, wrap_pulse, cnt_clr;
  logic [NUM_EV-1:0]  evt;
  logic [CNT_W-1:0]   cnt;
  logic               wr_ctrl, wr_ien, wr_clr, rearm;
  logic [5:0]         clr_bits;
  logic [5:1]         set_vec;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_ien   = reg_wr && (reg_addr == ADDR_IEN);
  assign wr_clr   = reg_wr && (reg_addr == ADDR_CLR);
  assign rearm    = wr_ctrl && reg_wdata[5];
  assign clr_bits = wr_clr ? reg_wdata[5:0] : 6'd0;
  assign set_vec  = {wrap_pulse, evt};
  assign cnt_clr  = |(evt & ctrl_q.rst_after);

  est_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sig_in), .rise(rise), .fall(fall)
  );

  est_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .fall_sel(ctrl_q.fall_sel), .wrap(ctrl_q.wrap), .one_shot(ctrl_q.one_shot),
    .prescale(ctrl_q.prescale), .rearm(rearm), .fire(fire), .evt(evt)
  );

  est_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .clr(cnt_clr),
    .cnt(cnt), .wrap_pulse(wrap_pulse)
  );

  // configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q        <= est_ctrl_t'(reg_wdata[23:0]);
        ctrl_q.rearm  <= 1'b0;
        ctrl_q.rsv_hi <= '0;
        ctrl_q.rsv_lo <= '0;
      end
      if (wr_ien) ien_q <= reg_wdata[5:1];
    end
  end

  // capture slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_EV; k++) cap_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_EV; k++)
        if (evt[k] && ctrl_q.load_en) cap_q[k] <= cnt;
    end
  end

  // sticky flags: a new set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_flag_q  <= '0;
      ovf_flag_q <= 1'b0;
      gint_q     <= 1'b0;
    end else begin
      ev_flag_q  <= (ev_flag_q & ~clr_bits[4:1]) | evt;
      ovf_flag_q <= (ovf_flag_q & ~clr_bits[BIT_OVF]) | wrap_pulse;
      gint_q     <= (gint_q & ~clr_bits[BIT_GINT]) | (|(set_vec & ien_q));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {8'd0, ctrl_q};
      ADDR_IEN:  reg_rdata = {26'd0, ien_q, 1'b0};
      ADDR_FLAG: reg_rdata = pack_flags(gint_q, ev_flag_q, ovf_flag_q);
      ADDR_CNT:  reg_rdata = 32'(cnt);
      4'h8, 4'h9, 4'hA, 4'hB: reg_rdata = 32'(cap_q[reg_addr[1:0]]);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = gint_q;

  for (genvar k = 0; k < NUM_EV; k++) begin : g_chk
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[k] && ctrl_q.load_en) |=> (cap_q[k] == $past(cnt))); // R3
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt[k] && ctrl_q.load_en) |=> $stable(cap_q[k])); // R8
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gint_q && !(|(set_vec & ien_q))) |=> !gint_q); // R12
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gint_q && !clr_bits[BIT_GINT]) |=> gint_q); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> ovf_flag_q); // R10
endmodule

// File: tb/sim_edge_stamp_timer.sv
module sim_edge_stamp_timer;
  localparam int CW   = 8;
  localparam int MODV = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  edge_stamp_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] cw(input bit run, input bit ld, input bit os,
                                     input logic [1:0] wrap, input bit rearm,
                                     input logic [4:0] pre, input logic [3:0] fsel,
                                     input logic [3:0] rst);
    return {8'h0, rst, fsel, 3'b0, pre, 2'b0, rearm, wrap, os, ld, run};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // change the input; return the capture value expected if it is an event
  task automatic edge_to(input logic v, output logic [31:0] exp_cap);
    logic [31:0] c;
    @(negedge clk);
    rd(4'h4, c);
    sig_in = v;
    exp_cap = (c + 2) % MODV;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); sig_in = 1'b1;
    repeat (4) @(negedge clk); sig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0, e1, e2, e3, e4, e5, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      rd(4'h8 + 4'(k), v); check("R1 cap reset", v, 0);
    end
    rd(4'h4, v); check("R1 counter reset", v, 0);
    rd(4'h2, v); check("R1 flags reset", v, 0);
    rd(4'h0, v); check("R1 ctrl reset", v, 0);
    check("R1 irq reset", {31'd0, irq}, 0);

    // R2 counter stopped then running
    repeat (5) @(negedge clk);
    rd(4'h4, v); check("R2 counter stopped", v, 0);
    wr(4'h0, cw(1, 1, 0, 2'd3, 0, 5'd0, 4'b1010, 4'b0000));
    rd(4'h4, c0);
    repeat (7) @(negedge clk);
    rd(4'h4, v); check("R2 counter step", v, (c0 + 7) % MODV);

    // R3 R4 alternating polarity absolute captures
    edge_to(1'b1, e1); edge_to(1'b0, e2); edge_to(1'b1, e3); edge_to(1'b0, e4);
    rd(4'h8, v); check("R3 cap1", v, e1);
    rd(4'h9, v); check("R4 cap2 falling", v, e2);
    rd(4'hA, v); check("R3 cap3", v, e3);
    rd(4'hB, v); check("R4 cap4 falling", v, e4);
    rd(4'h2, v); check("R11 event flags", v & 32'h1E, 32'h1E);
    // R6 continuous wrap returns to event 1
    edge_to(1'b1, e5);
    rd(4'h8, v); check("R6 wrap to cap1", v, e5);
    wr(4'h3, 32'h3F);
    rd(4'h2, v); check("R11 clear flags", v & 32'h1E, 0);

    // R4 wrong polarity ignored
    wr(4'h0, cw(1, 1, 0, 2'd3, 1, 5'd0, 4'b1010, 4'b0000));
    edge_to(1'b0, x);
    rd(4'h8, v); check("R4 falling ignored cap1", v, e5);
    rd(4'h2, v); check("R4 falling ignored flags", v & 32'h1E, 0);
    edge_to(1'b1, e1);
    rd(4'h8, v); check("R4 rising taken", v, e1);

    // R5 delta mode
    wr(4'h0, cw(1, 1, 0, 2'd3, 1, 5'd0, 4'b1010, 4'b1111));
    @(negedge clk); sig_in = 1'b0;
    repeat (4) @(negedge clk);
    sig_in = 1'b1; repeat (6) @(negedge clk);
    sig_in = 1'b0; repeat (9) @(negedge clk);
    sig_in = 1'b1; repeat (6) @(negedge clk);
    sig_in = 1'b0; repeat (5) @(negedge clk);
    rd(4'h9, v); check("R5 delta cap2", v, 5);
    rd(4'hA, v); check("R5 delta cap3", v, 8);
    rd(4'hB, v); check("R5 delta cap4", v, 5);
    rd(4'h4, v); check("R5 counter restarted", v, 2);

    // R6 wrap sweep
    for (int w = 0; w < 4; w++) begin
      wr(4'h0, cw(1, 1, 0, 2'(w), 1, 5'd0, 4'b0000, 4'b0000));
      wr(4'h3, 32'h3F);
      for (int p = 0; p <= w; p++) pulse();
      rd(4'h2, v); check("R6 events up to wrap", v & 32'h1E, ((32'd1 << (w + 1)) - 1) << 1);
      wr(4'h3, 32'h3F);
      pulse();
      rd(4'h2, v); check("R6 back to event1", v & 32'h1E, 32'h02);
    end

    // R7 one-shot and re-arm
    wr(4'h0, cw(1, 1, 1, 2'd1, 1, 5'd0, 4'b0000, 4'b0000));
    wr(4'h3, 32'h3F);
    edge_to(1'b1, e1); edge_to(1'b0, x); edge_to(1'b1, e2); edge_to(1'b0, x);
    rd(4'h9, v); check("R7 oneshot cap2", v, e2);
    wr(4'h3, 32'h3F);
    edge_to(1'b1, x);
    rd(4'h8, v); check("R7 stopped cap1 kept", v, e1);
    rd(4'h2, v); check("R7 stopped no flags", v & 32'h1E, 0);
    wr(4'h0, cw(1, 1, 1, 2'd1, 1, 5'd0, 4'b0000, 4'b0000));
    edge_to(1'b0, x); edge_to(1'b1, e3);
    rd(4'h8, v); check("R7 rearmed cap1", v, e3);

    // R8 load disabled
    wr(4'h0, cw(1, 0, 0, 2'd3, 1, 5'd0, 4'b0000, 4'b0000));
    wr(4'h3, 32'h3F);
    edge_to(1'b0, x); edge_to(1'b1, x);
    rd(4'h8, v); check("R8 cap1 unchanged", v, e3);
    rd(4'h2, v); check("R8 flag still set", v & 32'h1E, 32'h02);

    // R9 prescale by 2
    wr(4'h0, cw(1, 1, 0, 2'd3, 1, 5'd1, 4'b0000, 4'b0000));
    wr(4'h3, 32'h3F);
    edge_to(1'b0, x); edge_to(1'b1, x);
    rd(4'h2, v); check("R9 first edge swallowed", v & 32'h1E, 0);
    edge_to(1'b0, x); edge_to(1'b1, e4);
    rd(4'h2, v); check("R9 second edge event", v & 32'h1E, 32'h02);
    rd(4'h8, v); check("R9 prescaled cap1", v, e4);

    // R10 R11 R12 overflow and interrupt
    wr(4'h1, 32'h20);
    wr(4'h0, cw(1, 0, 0, 2'd0, 0, 5'd0, 4'b0000, 4'b0000));
    wr(4'h3, 32'h3F);
    repeat (300) @(negedge clk);
    wr(4'h0, 32'h0);
    rd(4'h2, v); check("R10 overflow flag", v & 32'h21, 32'h21);
    check("R12 irq on overflow", {31'd0, irq}, 1);
    wr(4'h3, 32'h00);
    rd(4'h2, v); check("R11 zero write no effect", v & 32'h21, 32'h21);
    wr(4'h3, 32'h20);
    rd(4'h2, v); check("R11 overflow cleared", v & 32'h20, 0);
    check("R12 irq held", {31'd0, irq}, 1);
    wr(4'h3, 32'h01);
    check("R12 irq cleared", {31'd0, irq}, 0);

    // R12 only enabled events raise irq
    wr(4'h1, 32'h02);
    wr(4'h0, cw(1, 1, 0, 2'd3, 1, 5'd0, 4'b0000, 4'b0000));
    wr(4'h3, 32'h3F);
    edge_to(1'b0, x); edge_to(1'b1, x);
    check("R12 irq from event1", {31'd0, irq}, 1);
    wr(4'h3, 32'h3F);
    edge_to(1'b0, x); edge_to(1'b1, x);
    rd(4'h2, v); check("R12 event2 flag", v & 32'h1E, 32'h04);
    check("R12 disabled event no irq", {31'd0, irq}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule